// File: doc/BRIEF.md
# Pad Loopback Stress Sequencer

This block stresses a bank of bidirectional pads by walking every output buffer through a fixed three-step drive pattern and checking what comes back on the matching input buffer. Each pad is controlled through a boundary-scan style output cell, which sets the value and the output enable. Each pad is also read through an input cell. Pads without a bonded pin are handled exactly like bonded ones. The whole bank steps together: first driven high, then released to high impedance, then driven low.

A two-bit mode input selects which receiver path feeds the input cells: the plain pad receiver, the reference-voltage comparator or the differential amplifier. This lets one sweep cover single-ended, voltage-referenced and differential standards. Each step lasts two cycles. The first cycle lets the loopback settle, and the compare happens at the edge that closes the second. While the output is released, a pad is compared against its keeper level only when that pad has one. Mismatches set a per-pad sticky flag and an aggregate flag. A new accepted start clears the flags.

Top module: `io_loop_stress`

## Requirements
- R1: After reset, all output enables and output values are 0, all error bits and the aggregate error are 0, and busy and done are 0.
- R2: A start seen while idle begins a sweep in the next cycle. For 6 cycles busy is 1 and every pad drives, for 2 cycles each: enable 1 with value 1 (high step), then enable 0 with value 0 (released step), then enable 1 with value 0 (low step). Outside a sweep the enable and value are 0.
- R3: The input is compared only at the clock edge that ends the second cycle of each step. A mismatch that is present only during the first cycle of a step is not flagged.
- R4: In the high step the expected read-back is 1, and in the low step it is 0. Each pad index, bonded or not, sets only its own error bit on a mismatch.
- R5: In the released step, a pad whose bit in parameter PULL_EN is 1 is expected to read its PULL_VAL bit. A pad whose PULL_EN bit is 0 is not compared in that step.
- R6: mode_i selects the receiver path: 0 = direct pad input, 1 = reference-voltage input, 2 = differential input, 3 = direct pad input. Values on the paths that are not selected have no effect on the error bits.
- R7: Error bits are sticky. They are cleared only by reset or by a start that is accepted while idle.
- R8: err_any_o is 1 exactly when at least one error bit is 1.
- R9: done_o is a one-cycle pulse in the cycle after the sweep's last compare, with busy then 0. A start raised while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a sweep (accepted only when idle) |
| mode_i | input | 2 | Receiver path select |
| pad_direct_i | input | N_PADS | Input cells, direct pad receiver |
| pad_vref_i | input | N_PADS | Input cells, reference-voltage receiver |
| pad_diff_i | input | N_PADS | Input cells, differential receiver |
| pad_out_o | output | N_PADS | Output cell drive value |
| pad_oe_o | output | N_PADS | Output cell enable |
| busy_o | output | 1 | Sweep in progress |
| done_o | output | 1 | Sweep finished pulse |
| err_o | output | N_PADS | Sticky per-pad mismatch flags |
| err_any_o | output | 1 | OR of all mismatch flags |

## Verification
If the step state is wrong, the pad enables and values at the ports differ from the expected six-cycle pattern within one cycle of the fault. It also moves the done pulse away from its fixed cycle, seven edges after the start. If the expected level or the compare timing is wrong, the pads flip the wrong way in err_o at the end of that same sweep. The bench injects faults into exactly one step, or into exactly one cycle of a step, so a shifted sample point or a swapped step shows up right away. Random noise on the receiver paths that are not selected exposes a wrong mode decode.

// File: rtl/io_ls_pkg.sv
package io_ls_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_H_DRV, ST_H_SMP, ST_Z_DRV, ST_Z_SMP, ST_L_DRV, ST_L_SMP
  } st_e;

  typedef enum logic [1:0] {PH_HIGH, PH_FLOAT, PH_LOW} ph_e;

  localparam logic [1:0] MODE_DIRECT = 2'd0;
  localparam logic [1:0] MODE_VREF   = 2'd1;
  localparam logic [1:0] MODE_DIFF   = 2'd2;
endpackage

// File: rtl/io_ls_seq.sv
module io_ls_seq
  import io_ls_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o,
  output logic drive_en_o,
  output logic drive_val_o,
  output logic smp_o,
  output logic clr_o,
  output logic done_o,
  output ph_e  ph_o
);
  st_e  st_q, st_d;
  logic done_q;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:  if (start_i) st_d = ST_H_DRV;
      ST_H_DRV: st_d = ST_H_SMP;
      ST_H_SMP: st_d = ST_Z_DRV;
      ST_Z_DRV: st_d = ST_Z_SMP;
      ST_Z_SMP: st_d = ST_L_DRV;
      ST_L_DRV: st_d = ST_L_SMP;
      ST_L_SMP: st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_q <= (st_q == ST_L_SMP);
    end
  end

  always_comb begin
    ph_o = PH_HIGH;
    unique case (st_q)
      ST_Z_DRV, ST_Z_SMP: ph_o = PH_FLOAT;
      ST_L_DRV, ST_L_SMP: ph_o = PH_LOW;
      default:            ph_o = PH_HIGH;
    endcase
  end

  assign busy_o      = (st_q != ST_IDLE);
  assign drive_en_o  = (st_q == ST_H_DRV) || (st_q == ST_H_SMP) ||
                       (st_q == ST_L_DRV) || (st_q == ST_L_SMP);
  assign drive_val_o = (st_q == ST_H_DRV) || (st_q == ST_H_SMP);
  assign smp_o       = (st_q == ST_H_SMP) || (st_q == ST_Z_SMP) || (st_q == ST_L_SMP);
  assign clr_o       = start_i && (st_q == ST_IDLE);
  assign done_o      = done_q;
endmodule

// File: rtl/io_ls_sel.sv
module io_ls_sel
  import io_ls_pkg::*;
#(
  parameter int N_PADS = 8
) (
  input  logic [1:0]        mode_i,
  input  logic [N_PADS-1:0] direct_i,
  input  logic [N_PADS-1:0] vref_i,
  input  logic [N_PADS-1:0] diff_i,
  output logic [N_PADS-1:0] rd_o
);
  for (genvar i = 0; i < N_PADS; i++) begin : g_pad
    always_comb begin
      unique case (mode_i)
        MODE_VREF: rd_o[i] = vref_i[i];
        MODE_DIFF: rd_o[i] = diff_i[i];
        default:   rd_o[i] = direct_i[i];
      endcase
    end
  end
endmodule

// File: rtl/io_ls_cmp.sv
module io_ls_cmp
  import io_ls_pkg::*;
#(
  parameter int                 N_PADS   = 8,
  parameter logic [N_PADS-1:0]  PULL_EN  = '0,
  parameter logic [N_PADS-1:0]  PULL_VAL = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              smp_i,
  input  ph_e               ph_i,
  input  logic [N_PADS-1:0] rd_i,
  output logic [N_PADS-1:0] err_o
);
  for (genvar i = 0; i < N_PADS; i++) begin : g_pad
    logic exp_b, chk_b;

    always_comb begin
      unique case (ph_i)
        PH_HIGH:  begin exp_b = 1'b1;        chk_b = 1'b1;        end
        PH_FLOAT: begin exp_b = PULL_VAL[i]; chk_b = PULL_EN[i];  end
        default:  begin exp_b = 1'b0;        chk_b = 1'b1;        end
      endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                 err_o[i] <= 1'b0;
      else if (clr_i)                              err_o[i] <= 1'b0;
      else if (smp_i && chk_b && (rd_i[i] != exp_b)) err_o[i] <= 1'b1;
    end
  end
endmodule

// File: rtl/io_loop_stress.sv
module io_loop_stress
  import io_ls_pkg::*;
#(
  parameter int                N_PADS   = 8,
  parameter logic [N_PADS-1:0] PULL_EN  = 8'b1011_0110,
  parameter logic [N_PADS-1:0] PULL_VAL = 8'b1001_0100
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [1:0]        mode_i,
  input  logic [N_PADS-1:0] pad_direct_i,
  input  logic [N_PADS-1:0] pad_vref_i,
  input  logic [N_PADS-1:0] pad_diff_i,
  output logic [N_PADS-1:0] pad_out_o,
  output logic [N_PADS-1:0] pad_oe_o,
  output logic              busy_o,
  output logic              done_o,
  output logic [N_PADS-1:0] err_o,
  output logic              err_any_o
);
  logic drive_en, drive_val, smp, clr;
  ph_e  ph;
  logic [N_PADS-1:0] rd;

  io_ls_seq i_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .busy_o      (busy_o),
    .drive_en_o  (drive_en),
    .drive_val_o (drive_val),
    .smp_o       (smp),
    .clr_o       (clr),
    .done_o      (done_o),
    .ph_o        (ph)
  );

  io_ls_sel #(.N_PADS(N_PADS)) i_sel (
    .mode_i   (mode_i),
    .direct_i (pad_direct_i),
    .vref_i   (pad_vref_i),
    .diff_i   (pad_diff_i),
    .rd_o     (rd)
  );

  io_ls_cmp #(.N_PADS(N_PADS), .PULL_EN(PULL_EN), .PULL_VAL(PULL_VAL)) i_cmp (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (clr),
    .smp_i  (smp),
    .ph_i   (ph),
    .rd_i   (rd),
    .err_o  (err_o)
  );

  for (genvar i = 0; i < N_PADS; i++) begin : g_cell
    assign pad_oe_o[i]  = drive_en;
    assign pad_out_o[i] = drive_en & drive_val;
  end

  assign err_any_o = |err_o;
endmodule

// File: rtl/io_loop_stress_chk.sv
module io_loop_stress_chk #(
  parameter int N_PADS = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              busy_o,
  input logic              done_o,
  input logic [N_PADS-1:0] pad_oe_o,
  input logic [N_PADS-1:0] pad_out_o,
  input logic [N_PADS-1:0] err_o,
  input logic              err_any_o
);
  AST_IDLE_NO_DRIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (pad_oe_o == '0 && pad_out_o == '0)); // R2
  AST_START_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> busy_o); // R2
  AST_UNIFORM_OE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (pad_oe_o == '0 || pad_oe_o == '1)); // R2
  AST_RELEASED_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pad_oe_o == '0) |-> (pad_out_o == '0)); // R2
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R9
  AST_DONE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o); // R9
  AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!start_i || busy_o) |=> ((err_o & $past(err_o)) == $past(err_o))); // R7
  AST_ERR_RISE_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_any_o) |-> $past(busy_o)); // R8
endmodule

bind io_loop_stress io_loop_stress_chk #(.N_PADS(N_PADS)) i_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .start_i   (start_i),
  .busy_o    (busy_o),
  .done_o    (done_o),
  .pad_oe_o  (pad_oe_o),
  .pad_out_o (pad_out_o),
  .err_o     (err_o),
  .err_any_o (err_any_o)
);

// File: tb/test_io_loop_stress.sv
module test_io_loop_stress;
  localparam int          N      = 8;
  localparam logic [N-1:0] PEN   = 8'b1011_0110;
  localparam logic [N-1:0] PVAL  = 8'b1001_0100;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [1:0] mode = 2'd0;
  logic [N-1:0] dir_in, vref_in, diff_in, pad_out, pad_oe, err;
  logic busy, done, err_any;
  logic [N-1:0] flt_h = '0, flt_z = '0, flt_l = '0, glitch = '0;
  logic [N-1:0] noise_f = '0, noise_x = '0;
  int checks = 0, fails = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  io_loop_stress #(.N_PADS(N), .PULL_EN(PEN), .PULL_VAL(PVAL)) i_io_loop_stress (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .mode_i(mode),
    .pad_direct_i(dir_in), .pad_vref_i(vref_in), .pad_diff_i(diff_in),
    .pad_out_o(pad_out), .pad_oe_o(pad_oe), .busy_o(busy), .done_o(done),
    .err_o(err), .err_any_o(err_any));

  // loopback model: keeper level when released, noise where no keeper
  always_comb begin
    for (int i = 0; i < N; i++) begin
      logic good, f, v;
      good = pad_oe[i] ? pad_out[i] : (PEN[i] ? PVAL[i] : noise_f[i]);
      f = pad_oe[i] ? (pad_out[i] ? flt_h[i] : flt_l[i]) : flt_z[i];
      v = good ^ f ^ glitch[i];
      dir_in[i]  = (mode == 2'd0 || mode == 2'd3) ? v : noise_x[i];
      vref_in[i] = (mode == 2'd1) ? v : ~noise_x[i];
      diff_in[i] = (mode == 2'd2) ? v : noise_x[i] ^ noise_f[i];
    end
  end

  function automatic logic [N-1:0] exp_err(input logic [N-1:0] h, z, l);
    return h | l | (z & PEN);
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  // glitch_cyc: cycle index (0..5) during which all read-backs are inverted, -1 none
  task automatic sweep(input logic [1:0] m, input logic [N-1:0] h, z, l,
                       input int glitch_cyc, input bit restart_mid);
    logic [N-1:0] expv;
    mode = m; flt_h = h; flt_z = z; flt_l = l;
    noise_f = N'($urandom); noise_x = N'($urandom);
    expv = exp_err(h, z, l);
    if (glitch_cyc == 1 || glitch_cyc == 5) expv = '1 | expv;
    if (glitch_cyc == 3) expv = expv | PEN;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    for (int c = 0; c < 6; c++) begin
      logic [N-1:0] eo, ev;
      glitch = (c == glitch_cyc) ? '1 : '0;
      if (restart_mid) start = (c == 1);
      eo = (c < 2 || c >= 4) ? '1 : '0;
      ev = (c < 2) ? '1 : '0;
      check("R2", {busy, pad_oe, pad_out}, {1'b1, eo, ev});
      @(negedge clk);
    end
    glitch = '0; start = 1'b0;
    check("R9", {busy, done}, 2'b01);
    check("R4/R5/R6", err, expv);
    check("R8", err_any, |expv);
    @(negedge clk);
    check("R9", done, 1'b0);
    flt_h = '0; flt_z = '0; flt_l = '0;
  endtask

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    check("R1", {pad_oe, pad_out, err, err_any, busy, done}, '0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", {pad_oe, pad_out, err, busy, done}, '0);

    sweep(2'd0, '0, '0, '0, -1, 0);                          // clean, R6 direct
    sweep(2'd1, 8'b0000_0001, '0, '0, -1, 0);                // R4 high, pad 0
    sweep(2'd2, '0, '0, 8'b1000_0000, -1, 0);                // R4 low, top pad
    sweep(2'd0, '0, 8'b0100_1001, '0, -1, 0);                // R5: only keeper pads flagged
    sweep(2'd3, '0, '0, 8'b0010_0000, -1, 0);                // R6 mode 3 direct
    sweep(2'd0, '0, '0, '0, 0, 0);                           // R3 drive-cycle glitch ignored
    sweep(2'd1, '0, '0, '0, 2, 0);
    sweep(2'd2, '0, '0, '0, 4, 0);
    sweep(2'd0, '0, '0, '0, 1, 0);                           // R3 sample-cycle glitch caught
    sweep(2'd1, '0, '0, '0, 3, 0);
    sweep(2'd2, '0, '0, '0, 5, 0);
    sweep(2'd0, 8'b0001_0000, '0, '0, -1, 1);                // R9 start while busy ignored
    repeat (5) @(negedge clk);
    check("R7", err, 8'b0001_0000);                          // sticky while idle
    sweep(2'd1, '0, '0, '0, -1, 0);
    check("R7", err, '0);                                    // cleared by new start

    for (int k = 0; k < 40; k++) begin
      logic [1:0] m;
      m = 2'($urandom_range(3));
      sweep(m, N'($urandom) & N'($urandom) & N'($urandom),
               N'($urandom) & N'($urandom),
               N'($urandom) & N'($urandom) & N'($urandom), -1, k[2]);
    end
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule